// File: doc/BRIEF.md
# Secondary-Link Flow Control Arbiter

This block merges two flow-control stop requests into the single stop signal that throttles an outgoing data stream. The primary acquisition link always has a say: whenever it asks for a stop, the stream stops. A second, optional consumer link also returns a stop request, but that request is disregarded until the consumer has deliberately armed itself. It arms by sending a fixed sixteen-nibble unlock pattern over its 4-bit return lines. It can disarm itself again at any time by sending an all-ones nibble.

The secondary return path is watched only while its recovered clock is reported present. When that clock vanishes (the consumer was power-cycled, unplugged or reloaded), the secondary stop is masked at once, so the primary link carries on alone. The partially matched pattern is also thrown away. The armed state is kept, so a short outage does not force the consumer to repeat the pattern. Link bring-up is not part of this block: the secondary side plays no role in it.

Top module: `flow_stop_merge`

## Requirements
- R1: `stop_o` equals `pri_stop_i` OR (`sec_stop_i` AND `sec_en_o` AND `sec_clk_ok_i`), combinationally in the same cycle.
- R2: After reset `sec_en_o` is 0, so `stop_o` follows `pri_stop_i` alone whatever `sec_stop_i` does.
- R3: `sec_en_o` becomes 1 on the clock edge that samples the last nibble of the unlock pattern D,1,E,2,A,3,D,4,B,5,A,6,B,7,E,8, sampled in that order (hex values on `sec_nib_i`). It is visible from that edge onward.
- R4: A sampled nibble 0xF clears `sec_en_o` on that edge and returns the matcher to the start of the pattern. This clear takes precedence over any match made in the same cycle.
- R5: A sampled nibble that is not the expected next one restarts the matcher. If that nibble is D, it counts as the first nibble of a new attempt, so the pattern can complete from the 1 that follows.
- R6: A nibble is sampled on a cycle where `sec_nib_vld_i` is 1, or where `sec_nib_i` differs from its value on the previous cycle. A value held with `sec_nib_vld_i` low is not sampled again.
- R7: While `sec_clk_ok_i` is 0: no nibble is sampled, the secondary stop is masked, and the matcher restarts. `sec_en_o` keeps its value.
- R8: A pattern that breaks off before its sixteenth nibble leaves `sec_en_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pri_stop_i | input | 1 | Stop request from the primary acquisition link |
| sec_stop_i | input | 1 | Stop request from the secondary consumer link |
| sec_nib_i | input | NIB_W (4) | Secondary return-line nibble |
| sec_nib_vld_i | input | 1 | Strobe that qualifies a nibble, including a repeated one |
| sec_clk_ok_i | input | 1 | Secondary recovered clock present |
| stop_o | output | 1 | Combined stop toward the data source |
| sec_en_o | output | 1 | Secondary stop armed (enable register) |

## Verification
The bench builds the block with its defaults: a 4-bit nibble, a sixteen-entry pattern, disarm code 0xF, and sampling on a strobe or on a change of value. The change-detect option lets the bench feed nibbles with no strobe at all, and test that a held value is not counted twice. The sixteen-entry depth brings the off-by-one cases within reach: fifteen matching nibbles, and a restart on D within a partly matched pattern. Random cycles mix clock dropouts, disarm codes and nibbles biased toward the next expected entry, so the block is armed and disarmed many times.

// File: rtl/fsm_pkg.sv
package fsm_pkg;

   // How a new return-line nibble is qualified for the matcher
   typedef enum logic {
      SAMPLE_STROBE_ONLY      = 1'b0,
      SAMPLE_STROBE_OR_CHANGE = 1'b1
   } sample_mode_e;

endpackage

// File: rtl/nib_sampler.sv
module nib_sampler
   import fsm_pkg::*;
#(
   parameter int           NIB_W = 4,
   parameter sample_mode_e MODE  = SAMPLE_STROBE_OR_CHANGE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NIB_W-1:0] nib_i,
   input  logic             vld_i,
   input  logic             clk_ok_i,
   output logic             smp_o
);

   generate
      if (MODE == SAMPLE_STROBE_OR_CHANGE) begin : g_change
         logic [NIB_W-1:0] nib_prev_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) nib_prev_q <= '0;
            else        nib_prev_q <= nib_i;
         end

         assign smp_o = clk_ok_i && (vld_i || (nib_i != nib_prev_q));

         // a held value with no strobe must not produce a sample
         AST_HELD_NOT_RESAMPLED: assert property (@(posedge clk) disable iff (!rst_n)
            (!vld_i && $stable(nib_i)) |-> !smp_o); // R6
      end else begin : g_strobe
         assign smp_o = clk_ok_i && vld_i;
      end
   endgenerate

   AST_NO_SAMPLE_CLK_LOST: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_ok_i |-> !smp_o); // R7

endmodule

// File: rtl/unlock_matcher.sv
module unlock_matcher #(
   parameter int                     NIB_W      = 4,
   parameter int                     SEQ_LEN    = 16,
   parameter logic [SEQ_LEN*NIB_W-1:0] UNLOCK_SEQ = 64'hD1E2_A3D4_B5A6_B7E8,
   parameter logic [NIB_W-1:0]       DISARM     = 4'hF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NIB_W-1:0] nib_i,
   input  logic             smp_i,
   input  logic             clk_ok_i,
   output logic             en_o
);

   localparam int               POS_W = $clog2(SEQ_LEN);
   localparam logic [POS_W-1:0] LAST  = POS_W'(SEQ_LEN - 1);

   // expected nibble per position; position 0 sits in the top nibble
   logic [NIB_W-1:0] exp_tbl [SEQ_LEN];

   generate
      for (genvar gi = 0; gi < SEQ_LEN; gi++) begin : g_tbl
         assign exp_tbl[gi] = UNLOCK_SEQ[(SEQ_LEN-1-gi)*NIB_W +: NIB_W];
      end
   endgenerate

   logic [POS_W-1:0] pos_q, pos_d;
   logic             en_q, en_d;
   logic             hit, hit_last, is_disarm, is_head;

   assign hit       = (nib_i == exp_tbl[pos_q]);
   assign hit_last  = hit && (pos_q == LAST);
   assign is_disarm = (nib_i == DISARM);
   assign is_head   = (nib_i == exp_tbl[0]);

   always_comb begin
      pos_d = pos_q;
      en_d  = en_q;
      if (!clk_ok_i) begin
         pos_d = '0;
      end else if (smp_i) begin
         if (is_disarm) begin
            pos_d = '0;
            en_d  = 1'b0;
         end else if (hit_last) begin
            pos_d = '0;
            en_d  = 1'b1;
         end else if (hit) begin
            pos_d = pos_q + 1'b1;
         end else if (is_head) begin
            pos_d = POS_W'(1);
         end else begin
            pos_d = '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
         en_q  <= 1'b0;
      end else begin
         pos_q <= pos_d;
         en_q  <= en_d;
      end
   end

   assign en_o = en_q;

   AST_ARM_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_q) |-> $past(smp_i && clk_ok_i && pos_q == LAST && nib_i == exp_tbl[LAST])); // R3
   AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_i && nib_i == DISARM) |=> (!en_q && pos_q == '0)); // R4
   AST_CLK_LOSS_HOLDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_ok_i |=> $stable(en_q)); // R7
   AST_CLK_LOSS_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_ok_i |=> (pos_q == '0)); // R7
   AST_HEAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_i && clk_ok_i && !hit && is_head && !is_disarm) |=> (pos_q == POS_W'(1))); // R5

endmodule

// File: rtl/stop_combiner.sv
module stop_combiner (
   input  logic clk,
   input  logic rst_n,
   input  logic pri_stop_i,
   input  logic sec_stop_i,
   input  logic en_i,
   input  logic clk_ok_i,
   output logic stop_o
);

   logic sec_eff;

   assign sec_eff = sec_stop_i && en_i && clk_ok_i;
   assign stop_o  = pri_stop_i || sec_eff;

   AST_PRIMARY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      pri_stop_i |-> stop_o); // R1
   AST_SEC_MASKED_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |-> (stop_o == pri_stop_i)); // R2
   AST_SEC_MASKED_NO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_ok_i |-> (stop_o == pri_stop_i)); // R7

endmodule

// File: rtl/flow_stop_merge.sv
module flow_stop_merge
   import fsm_pkg::*;
#(
   parameter int                       NIB_W      = 4,
   parameter int                       SEQ_LEN    = 16,
   parameter logic [SEQ_LEN*NIB_W-1:0] UNLOCK_SEQ = 64'hD1E2_A3D4_B5A6_B7E8,
   parameter logic [NIB_W-1:0]         DISARM     = 4'hF,
   parameter sample_mode_e             MODE       = SAMPLE_STROBE_OR_CHANGE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pri_stop_i,
   input  logic             sec_stop_i,
   input  logic [NIB_W-1:0] sec_nib_i,
   input  logic             sec_nib_vld_i,
   input  logic             sec_clk_ok_i,
   output logic             stop_o,
   output logic             sec_en_o
);

   generate
      if (NIB_W < 2) begin : g_bad_w
         $error("flow_stop_merge: NIB_W must be at least 2");
      end
      if (SEQ_LEN < 2) begin : g_bad_len
         $error("flow_stop_merge: SEQ_LEN must be at least 2");
      end
      if (UNLOCK_SEQ[(SEQ_LEN-1)*NIB_W +: NIB_W] == DISARM) begin : g_bad_head
         $error("flow_stop_merge: pattern must not start with the disarm code");
      end
   endgenerate

   logic smp;
   logic en;

   nib_sampler #(
      .NIB_W (NIB_W),
      .MODE  (MODE)
   ) u_smp (
      .clk      (clk),
      .rst_n    (rst_n),
      .nib_i    (sec_nib_i),
      .vld_i    (sec_nib_vld_i),
      .clk_ok_i (sec_clk_ok_i),
      .smp_o    (smp)
   );

   unlock_matcher #(
      .NIB_W      (NIB_W),
      .SEQ_LEN    (SEQ_LEN),
      .UNLOCK_SEQ (UNLOCK_SEQ),
      .DISARM     (DISARM)
   ) u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .nib_i    (sec_nib_i),
      .smp_i    (smp),
      .clk_ok_i (sec_clk_ok_i),
      .en_o     (en)
   );

   stop_combiner u_comb (
      .clk        (clk),
      .rst_n      (rst_n),
      .pri_stop_i (pri_stop_i),
      .sec_stop_i (sec_stop_i),
      .en_i       (en),
      .clk_ok_i   (sec_clk_ok_i),
      .stop_o     (stop_o)
   );

   assign sec_en_o = en;

endmodule

// File: tb/tb_flow_stop_merge.sv
module tb_flow_stop_merge;

   localparam int          CLK_PERIOD = 10;
   localparam logic [63:0] PATTERN    = 64'hD1E2_A3D4_B5A6_B7E8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pri = 1'b0, sec = 1'b0, stb = 1'b0, ok = 1'b0;
   logic [3:0] nib = 4'h0;
   logic       stop_o, sec_en_o;

   int n_chk = 0, n_fail = 0;

   // reference state, derived from the requirements
   int         rpos = 0;
   logic       ren = 1'b0;
   logic [3:0] rprev = 4'h0;

   flow_stop_merge dut (
      .clk(clk), .rst_n(rst_n), .pri_stop_i(pri), .sec_stop_i(sec),
      .sec_nib_i(nib), .sec_nib_vld_i(stb), .sec_clk_ok_i(ok),
      .stop_o(stop_o), .sec_en_o(sec_en_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [3:0] exp_nib(int p);
      return PATTERN[(15-p)*4 +: 4];
   endfunction

   function automatic logic exp_stop(logic p, logic s, logic e, logic k);
      return p | (s & e & k);
   endfunction

   task automatic check(logic act, logic exp, string req);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   // one cycle: drive inputs, check the combined stop, clock, check the enable
   task automatic cyc(logic p, logic s, logic [3:0] n, logic v, logic k, string req);
      logic smp;
      pri = p; sec = s; nib = n; stb = v; ok = k;
      #2;
      check(stop_o, exp_stop(p, s, ren, k), "R1");
      smp = k && (v || (n != rprev));
      rprev = n;
      if (!k) rpos = 0;
      else if (smp) begin
         if (n == 4'hF) begin rpos = 0; ren = 1'b0; end
         else if (n == exp_nib(rpos)) begin
            if (rpos == 15) begin rpos = 0; ren = 1'b1; end
            else rpos++;
         end else rpos = (n == exp_nib(0)) ? 1 : 0;
      end
      @(posedge clk);
      #1;
      check(sec_en_o, ren, req);
   endtask

   task automatic send(logic [3:0] n, string req);
      cyc(1'b0, 1'b0, n, 1'b1, 1'b1, req);
   endtask

   task automatic send_range(int from, int to, string req);
      for (int i = from; i <= to; i++) send(exp_nib(i), req);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0C42));
      repeat (3) @(posedge clk);
      #1;
      // R2: reset state
      check(sec_en_o, 1'b0, "R2");
      rst_n = 1'b1;
      cyc(1'b0, 1'b1, 4'h0, 1'b0, 1'b1, "R2");
      check(stop_o, 1'b0, "R2");
      cyc(1'b1, 1'b1, 4'h0, 1'b0, 1'b1, "R2");

      // R8: fifteen nibbles only, then R3: the sixteenth arms
      send_range(0, 14, "R8");
      check(sec_en_o, 1'b0, "R8");
      send(exp_nib(15), "R3");
      check(sec_en_o, 1'b1, "R3");
      cyc(1'b0, 1'b1, 4'h8, 1'b0, 1'b1, "R1");
      check(stop_o, 1'b1, "R1");

      // R7: clock loss masks secondary stop, enable is kept
      cyc(1'b0, 1'b1, 4'h8, 1'b0, 1'b0, "R7");
      cyc(1'b0, 1'b1, 4'hF, 1'b1, 1'b0, "R7");
      check(sec_en_o, 1'b1, "R7");
      #2; check(stop_o, 1'b0, "R7");

      // R4: disarm
      send(4'hF, "R4");
      check(sec_en_o, 1'b0, "R4");
      // R4: disarm mid-pattern restarts matcher
      send_range(0, 7, "R4");
      send(4'hF, "R4");
      send_range(8, 15, "R4");
      check(sec_en_o, 1'b0, "R4");

      // R5: restart on D within a partial pattern
      send_range(0, 2, "R5");
      send(4'hD, "R5");
      send_range(1, 15, "R5");
      check(sec_en_o, 1'b1, "R5");
      send(4'hF, "R4");

      // R7: clock loss mid-pattern discards progress
      send_range(0, 7, "R7");
      cyc(1'b0, 1'b0, exp_nib(7), 1'b0, 1'b0, "R7");
      send_range(8, 15, "R7");
      check(sec_en_o, 1'b0, "R7");

      // R6: change-only sampling, and held values not re-counted
      for (int i = 0; i < 16; i++) begin
         cyc(1'b0, 1'b0, exp_nib(i), 1'b0, 1'b1, "R6");
         cyc(1'b0, 1'b0, exp_nib(i), 1'b0, 1'b1, "R6");
      end
      check(sec_en_o, 1'b1, "R6");
      send(4'hF, "R4");
      // repeated nibble with strobe is a mismatch
      send_range(0, 4, "R6");
      send(exp_nib(4), "R6");
      send_range(5, 15, "R6");
      check(sec_en_o, 1'b0, "R6");

      // random mix against the reference model
      for (int i = 0; i < 4000; i++) begin
         logic [3:0] n;
         logic       v, k;
         int         r;
         r = int'($urandom_range(99));
         k = ($urandom_range(49) != 0);
         if (r < 65)      begin n = exp_nib(rpos); v = 1'b1; end
         else if (r < 70) begin n = 4'hF;          v = 1'b1; end
         else if (r < 85) begin n = 4'($urandom()); v = 1'b1; end
         else             begin n = rprev;          v = 1'b0; end
         cyc(1'($urandom()), 1'($urandom()), n, v, k, "R3");
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule